// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sits next to the CPU and decides what happens when the CPU asks to sleep. A request comes as a one-cycle pulse of one of two kinds: wait-for-interrupt or wait-for-event. The controller refuses the request if the matching kind of wake-up is already pending. Otherwise it uses the deep-sleep flag and two control bits to pick a mode:

- **Sleep** stops only the CPU clock.
- **Stop** stops every core-domain clock and the oscillators. The regulator runs either in main or in low-power mode.
- **Standby** also switches the core regulator off.

Entry into Stop or Standby waits until any flash programming and any peripheral-bus transfer have finished. While it waits, the block reports Run.

The block also decides when each mode ends:

- **Sleep** ends on the same kind of pending condition that was used to enter it.
- **Stop** ends on any configured wake line. The system clock then switches to the internal RC oscillator. If the low-power regulator was selected, the clocks are held off for a programmable number of cycles first.
- **Standby** ends only on a wake-pin rising edge, an RTC event or an external or watchdog reset source. It does not resume execution: it issues a one-cycle system reset request and then returns to Run.

**States:** RUN, DRAIN (waiting for flash and bus to go idle), SLEEP, STOP, STOP_WAIT (regulator recovery), STANDBY and RST_REQ (reset request).

**Transitions:**
- RUN to SLEEP on an accepted shallow request.
- RUN to DRAIN on an accepted deep request while flash or bus is busy.
- RUN to STOP or STANDBY on an accepted deep request while both are idle.
- DRAIN to STOP or STANDBY once flash and bus are idle.
- SLEEP to RUN on the matching pending condition.
- STOP to RUN on a wake line with the main regulator.
- STOP to STOP_WAIT on a wake line with the low-power regulator.
- STOP_WAIT to RUN when the count expires.
- STANDBY to RST_REQ on a Standby wake source.
- RST_REQ to RUN after one cycle.

Top module: `lpm_ctrl`

## Requirements
- R1: A request is refused, and the block stays in Run, when it is wait-for-interrupt and irq_pend is 1, or when it is wait-for-event and evt_pend is 1. A wait-for-event request is not blocked by irq_pend. If both request pulses arrive together, the request is treated as wait-for-interrupt.
- R2: An accepted request with deep_sel=0 sets mode to 1 (Sleep) on the next clock, with cpu_clk_en=0, core_clk_en=1 and osc_en=1.
- R3: Sleep entered by wait-for-interrupt ends when irq_pend is 1. Sleep entered by wait-for-event ends when evt_pend is 1, and irq_pend has no effect on it. Run (mode 0, all clock enables 1) follows on the next clock.
- R4: An accepted request with deep_sel=1 and pd_deep=0 enters mode 2 (Stop), with cpu_clk_en, core_clk_en and osc_en all 0. In Stop, reg_lp_sel equals the lp_deep value sampled when the request was accepted.
- R5: An accepted request with deep_sel=1 and pd_deep=1 enters mode 3 (Standby), with reg_on=0 and all clock enables 0.
- R6: While flash_busy or apb_busy is 1, an accepted Stop or Standby request is held with mode 0. The mode is entered on the clock after both busy inputs are 0.
- R7: Stop with the main regulator returns to Run on the clock after stop_wake=1. rtc_evt, wake_pin and ext_wake_rst have no effect in Stop.
- R8: Stop with the low-power regulator, on stop_wake=1, stays in mode 2 with osc_en=1 and reg_lp_sel=0 for lp_wait_cnt+1 clocks, then returns to Run.
- R9: sys_clk_rc becomes 1 on leaving Stop and remains 1 until reset.
- R10: Standby ends on a 0-to-1 transition of any wake_pin bit, on any rtc_evt bit, or on ext_wake_rst. A pin that was already high before entry does not end Standby, and stop_wake has no effect in Standby. Exit gives sys_rst_req=1 with reg_on=1 for exactly one clock, followed by Run.
- R11: A Standby request is refused while wake_flag=1. A Stop request is not affected by wake_flag.
- R12: After reset: mode=0, cpu_clk_en, core_clk_en, osc_en and reg_on all 1, and reg_lp_sel, sys_clk_rc and sys_rst_req all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wfi | input | 1 | Wait-for-interrupt sleep request pulse |
| req_wfe | input | 1 | Wait-for-event sleep request pulse |
| deep_sel | input | 1 | Deep-sleep flag: 1 selects Stop or Standby |
| pd_deep | input | 1 | 1 selects Standby instead of Stop |
| lp_deep | input | 1 | 1 selects the low-power regulator in Stop |
| irq_pend | input | 1 | An interrupt is pending |
| evt_pend | input | 1 | An event is pending |
| flash_busy | input | 1 | Flash programming in progress |
| apb_busy | input | 1 | Peripheral-bus access in progress |
| wake_flag | input | 1 | Wake-up flag still set (blocks Standby) |
| stop_wake | input | 1 | Any configured wake line (ends Stop) |
| wake_pin | input | N_PINS | Standby wake pins, active on rising edge |
| rtc_evt | input | N_RTC | RTC alarm, wake-up, tamper and timestamp events |
| ext_wake_rst | input | 1 | External or watchdog reset source |
| lp_wait_cnt | input | CNT_W | Regulator recovery wait, in cycles minus one |
| mode | output | 2 | 0 Run, 1 Sleep, 2 Stop, 3 Standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| core_clk_en | output | 1 | Core-domain clock enable |
| osc_en | output | 1 | Oscillator enable |
| reg_on | output | 1 | Core regulator enable |
| reg_lp_sel | output | 1 | Low-power regulator select |
| sys_clk_rc | output | 1 | System clock taken from the internal RC oscillator |
| sys_rst_req | output | 1 | System reset request on Standby exit |

## Verification
The bench sends requests with each pending input high and then low, to show which kind of pending condition blocks which kind of request. It walks through every combination of deep_sel and pd_deep, to show that the three target modes are selected correctly.

Each mode is also given the wake sources that belong to other modes, to confirm they are ignored:
- interrupts while in event-entered Sleep;
- RTC events while in Stop;
- stop_wake, and a pin held high from before entry, while in Standby.

Busy inputs that drop one at a time check that deep entry is delayed. A non-zero recovery count checks the exact length of the low-power Stop exit.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_STOP    = 2'd2,
        MODE_STANDBY = 2'd3
    } lpm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_DRAIN     = 3'd1,
        ST_SLEEP     = 3'd2,
        ST_STOP      = 3'd3,
        ST_STOP_WAIT = 3'd4,
        ST_STANDBY   = 3'd5,
        ST_RST_REQ   = 3'd6
    } lpm_state_e;

    typedef enum logic [1:0] {
        TGT_SLEEP   = 2'd0,
        TGT_STOP    = 2'd1,
        TGT_STANDBY = 2'd2
    } lpm_target_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      cpu_clk_en;
        logic      core_clk_en;
        logic      osc_en;
        logic      reg_on;
        logic      reg_lp_sel;
        logic      sys_rst_req;
    } lpm_ctl_s;

endpackage

// File: rtl/lpm_entry_gate.sv
module lpm_entry_gate
    import lpm_pkg::*;
(
    input  logic        req_wfi,
    input  logic        req_wfe,
    input  logic        deep_sel,
    input  logic        pd_deep,
    input  logic        irq_pend,
    input  logic        evt_pend,
    input  logic        wake_flag,
    output logic        accept,
    output logic        kind_wfe,
    output lpm_target_e target
);

    logic any_req;
    logic blocked;

    always_comb begin
        any_req  = req_wfi | req_wfe;
        // Wait-for-interrupt wins when both pulses arrive together.
        kind_wfe = req_wfe & ~req_wfi;
        blocked  = kind_wfe ? evt_pend : irq_pend;

        if (!deep_sel) begin
            target = TGT_SLEEP;
        end else if (pd_deep) begin
            target = TGT_STANDBY;
        end else begin
            target = TGT_STOP;
        end

        accept = any_req & ~blocked & ~((target == TGT_STANDBY) & wake_flag);
    end

endmodule

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect
    import lpm_pkg::*;
#(
    parameter int N_PINS = 2,
    parameter int N_RTC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] wake_pin,
    input  logic [N_RTC-1:0]  rtc_evt,
    input  logic              ext_wake_rst,
    input  logic              sleep_wfe,
    input  logic              irq_pend,
    input  logic              evt_pend,
    output logic              sb_wake,
    output logic              sleep_exit
);

    logic [N_PINS-1:0] pin_q;
    logic [N_PINS-1:0] pin_rise;

    // One edge detector per pin; the history runs in every state.
    for (genvar gi = 0; gi < N_PINS; gi++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_q[gi] <= 1'b0;
            end else begin
                pin_q[gi] <= wake_pin[gi];
            end
        end
        assign pin_rise[gi] = wake_pin[gi] & ~pin_q[gi];
    end

    always_comb begin
        sb_wake    = (|pin_rise) | (|rtc_evt) | ext_wake_rst;
        sleep_exit = sleep_wfe ? evt_pend : irq_pend;
    end

endmodule

// File: rtl/lpm_wait_timer.sv
module lpm_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_PINS = 2,
    parameter int N_RTC  = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wfi,
    input  logic              req_wfe,
    input  logic              deep_sel,
    input  logic              pd_deep,
    input  logic              lp_deep,
    input  logic              irq_pend,
    input  logic              evt_pend,
    input  logic              flash_busy,
    input  logic              apb_busy,
    input  logic              wake_flag,
    input  logic              stop_wake,
    input  logic [N_PINS-1:0] wake_pin,
    input  logic [N_RTC-1:0]  rtc_evt,
    input  logic              ext_wake_rst,
    input  logic [CNT_W-1:0]  lp_wait_cnt,
    output logic [1:0]        mode,
    output logic              cpu_clk_en,
    output logic              core_clk_en,
    output logic              osc_en,
    output logic              reg_on,
    output logic              reg_lp_sel,
    output logic              sys_clk_rc,
    output logic              sys_rst_req
);

    lpm_state_e  state_q, state_d;
    lpm_target_e target_q, gate_target;
    logic        wfe_q, lp_q, rc_q;
    logic        accept, kind_wfe;
    logic        sb_wake, sleep_exit;
    logic        busy, tmr_load, tmr_done;
    lpm_ctl_s    ctl;

    lpm_entry_gate u_gate (
        .req_wfi   (req_wfi),
        .req_wfe   (req_wfe),
        .deep_sel  (deep_sel),
        .pd_deep   (pd_deep),
        .irq_pend  (irq_pend),
        .evt_pend  (evt_pend),
        .wake_flag (wake_flag),
        .accept    (accept),
        .kind_wfe  (kind_wfe),
        .target    (gate_target)
    );

    lpm_wake_detect #(
        .N_PINS (N_PINS),
        .N_RTC  (N_RTC)
    ) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_pin     (wake_pin),
        .rtc_evt      (rtc_evt),
        .ext_wake_rst (ext_wake_rst),
        .sleep_wfe    (wfe_q),
        .irq_pend     (irq_pend),
        .evt_pend     (evt_pend),
        .sb_wake      (sb_wake),
        .sleep_exit   (sleep_exit)
    );

    assign tmr_load = (state_q == ST_STOP) & stop_wake & lp_q;

    lpm_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (lp_wait_cnt),
        .run      (state_q == ST_STOP_WAIT),
        .done     (tmr_done)
    );

    assign busy = flash_busy | apb_busy;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept) begin
                    if (gate_target == TGT_SLEEP) begin
                        state_d = ST_SLEEP;
                    end else if (busy) begin
                        state_d = ST_DRAIN;
                    end else if (gate_target == TGT_STANDBY) begin
                        state_d = ST_STANDBY;
                    end else begin
                        state_d = ST_STOP;
                    end
                end
            end
            ST_DRAIN: begin
                if (!busy) begin
                    state_d = (target_q == TGT_STANDBY) ? ST_STANDBY : ST_STOP;
                end
            end
            ST_SLEEP: begin
                if (sleep_exit) state_d = ST_RUN;
            end
            ST_STOP: begin
                if (stop_wake) state_d = lp_q ? ST_STOP_WAIT : ST_RUN;
            end
            ST_STOP_WAIT: begin
                if (tmr_done) state_d = ST_RUN;
            end
            ST_STANDBY: begin
                if (sb_wake) state_d = ST_RST_REQ;
            end
            ST_RST_REQ: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            target_q <= TGT_SLEEP;
            wfe_q    <= 1'b0;
            lp_q     <= 1'b0;
            rc_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && accept) begin
                target_q <= gate_target;
                wfe_q    <= kind_wfe;
                lp_q     <= lp_deep;
            end
            if (state_q == ST_STOP && stop_wake) begin
                rc_q <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        ctl = '{mode: MODE_RUN, cpu_clk_en: 1'b1, core_clk_en: 1'b1,
                osc_en: 1'b1, reg_on: 1'b1, reg_lp_sel: 1'b0,
                sys_rst_req: 1'b0};
        unique case (state_q)
            ST_RUN, ST_DRAIN: begin
            end
            ST_SLEEP: begin
                ctl.mode       = MODE_SLEEP;
                ctl.cpu_clk_en = 1'b0;
            end
            ST_STOP: begin
                ctl.mode        = MODE_STOP;
                ctl.cpu_clk_en  = 1'b0;
                ctl.core_clk_en = 1'b0;
                ctl.osc_en      = 1'b0;
                ctl.reg_lp_sel  = lp_q;
            end
            ST_STOP_WAIT: begin
                ctl.mode        = MODE_STOP;
                ctl.cpu_clk_en  = 1'b0;
                ctl.core_clk_en = 1'b0;
            end
            ST_STANDBY: begin
                ctl.mode        = MODE_STANDBY;
                ctl.cpu_clk_en  = 1'b0;
                ctl.core_clk_en = 1'b0;
                ctl.osc_en      = 1'b0;
                ctl.reg_on      = 1'b0;
            end
            ST_RST_REQ: begin
                ctl.mode        = MODE_STANDBY;
                ctl.cpu_clk_en  = 1'b0;
                ctl.core_clk_en = 1'b0;
                ctl.sys_rst_req = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mode        = ctl.mode;
    assign cpu_clk_en  = ctl.cpu_clk_en;
    assign core_clk_en = ctl.core_clk_en;
    assign osc_en      = ctl.osc_en;
    assign reg_on      = ctl.reg_on;
    assign reg_lp_sel  = ctl.reg_lp_sel;
    assign sys_rst_req = ctl.sys_rst_req;
    assign sys_clk_rc  = rc_q;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
    import lpm_pkg::*;
#(
    parameter int N_RTC = 5
) (
    input logic             clk,
    input logic             rst_n,
    input lpm_state_e       st,
    input logic             req_wfi,
    input logic             deep_sel,
    input logic             pd_deep,
    input logic             irq_pend,
    input logic             wake_flag,
    input logic             flash_busy,
    input logic             apb_busy,
    input logic             stop_wake,
    input logic [N_RTC-1:0] rtc_evt,
    input logic [1:0]       mode,
    input logic             cpu_clk_en,
    input logic             sys_clk_rc,
    input logic             sys_rst_req
);

    assert_refuse_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && req_wfi && irq_pend) |=> mode == MODE_RUN);

    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && req_wfi && !irq_pend && !deep_sel)
        |=> (mode == MODE_SLEEP && !cpu_clk_en));

    assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && (flash_busy || apb_busy)) |=> mode == MODE_RUN);

    assert_rc_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && stop_wake) |=> sys_clk_rc);

    assert_rc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clk_rc |=> sys_clk_rc);

    assert_sb_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STANDBY && rtc_evt != '0) |=> sys_rst_req);

    assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> (!sys_rst_req && mode == MODE_RUN));

    assert_sb_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wake_flag && deep_sel && pd_deep) |=> st == ST_RUN);

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_RTC(N_RTC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (state_q),
    .req_wfi     (req_wfi),
    .deep_sel    (deep_sel),
    .pd_deep     (pd_deep),
    .irq_pend    (irq_pend),
    .wake_flag   (wake_flag),
    .flash_busy  (flash_busy),
    .apb_busy    (apb_busy),
    .stop_wake   (stop_wake),
    .rtc_evt     (rtc_evt),
    .mode        (mode),
    .cpu_clk_en  (cpu_clk_en),
    .sys_clk_rc  (sys_clk_rc),
    .sys_rst_req (sys_rst_req)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;

    localparam int N_PINS = 2;
    localparam int N_RTC  = 5;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_wfi = 0, req_wfe = 0, deep_sel = 0, pd_deep = 0, lp_deep = 0;
    logic irq_pend = 0, evt_pend = 0, flash_busy = 0, apb_busy = 0;
    logic wake_flag = 0, stop_wake = 0, ext_wake_rst = 0;
    logic [N_PINS-1:0] wake_pin = '0;
    logic [N_RTC-1:0]  rtc_evt = '0;
    logic [CNT_W-1:0]  lp_wait_cnt = '0;
    logic [1:0] mode;
    logic cpu_clk_en, core_clk_en, osc_en, reg_on, reg_lp_sel, sys_clk_rc, sys_rst_req;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    lpm_ctrl #(.N_PINS(N_PINS), .N_RTC(N_RTC), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_wfi(req_wfi), .req_wfe(req_wfe),
        .deep_sel(deep_sel), .pd_deep(pd_deep), .lp_deep(lp_deep),
        .irq_pend(irq_pend), .evt_pend(evt_pend), .flash_busy(flash_busy),
        .apb_busy(apb_busy), .wake_flag(wake_flag), .stop_wake(stop_wake),
        .wake_pin(wake_pin), .rtc_evt(rtc_evt), .ext_wake_rst(ext_wake_rst),
        .lp_wait_cnt(lp_wait_cnt), .mode(mode), .cpu_clk_en(cpu_clk_en),
        .core_clk_en(core_clk_en), .osc_en(osc_en), .reg_on(reg_on),
        .reg_lp_sel(reg_lp_sel), .sys_clk_rc(sys_clk_rc), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_wfi();
        req_wfi = 1'b1; tick(); req_wfi = 1'b0;
    endtask

    task automatic pulse_wfe();
        req_wfe = 1'b1; tick(); req_wfe = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 mode", mode, 0);
        chk("R12 clocks", {cpu_clk_en, core_clk_en, osc_en, reg_on}, 4'hF);
        chk("R12 lp/rc/rst", {reg_lp_sel, sys_clk_rc, sys_rst_req}, 0);
    endtask

    task automatic t_refuse();
        irq_pend = 1; pulse_wfi();
        chk("R1 wfi refused", mode, 0);
        irq_pend = 0; evt_pend = 1; pulse_wfe();
        chk("R1 wfe refused", mode, 0);
        evt_pend = 0; irq_pend = 1; pulse_wfe();
        chk("R1 wfe not blocked by irq", mode, 1);
        tick();
        chk("R3 irq ignored in wfe sleep", mode, 1);
        evt_pend = 1; tick();
        chk("R3 wfe sleep exit", mode, 0);
        irq_pend = 0; evt_pend = 0;
    endtask

    task automatic t_sleep_wfi();
        deep_sel = 0; pulse_wfi();
        chk("R2 sleep mode", mode, 1);
        chk("R2 sleep clocks", {cpu_clk_en, core_clk_en, osc_en}, 3'b011);
        evt_pend = 1; tick();
        chk("R3 evt ignored in wfi sleep", mode, 1);
        evt_pend = 0; irq_pend = 1; tick();
        chk("R3 wfi sleep exit", mode, 0);
        chk("R3 run clocks", {cpu_clk_en, core_clk_en, osc_en}, 3'b111);
        irq_pend = 0;
    endtask

    task automatic t_stop_main();
        deep_sel = 1; pd_deep = 0; lp_deep = 0; pulse_wfi();
        chk("R4 stop mode", mode, 2);
        chk("R4 stop clocks off", {cpu_clk_en, core_clk_en, osc_en}, 0);
        chk("R4 main regulator", reg_lp_sel, 0);
        chk("R9 rc not yet", sys_clk_rc, 0);
        rtc_evt = 5'b00100; ext_wake_rst = 1; wake_pin = 2'b01; tick();
        rtc_evt = '0; ext_wake_rst = 0;
        chk("R7 standby sources ignored", mode, 2);
        stop_wake = 1; tick(); stop_wake = 0;
        chk("R7 stop exit", mode, 0);
        chk("R9 rc selected", sys_clk_rc, 1);
        wake_pin = '0;
        tick();
        chk("R9 rc held", sys_clk_rc, 1);
    endtask

    task automatic t_stop_lp();
        int n;
        deep_sel = 1; pd_deep = 0; lp_deep = 1; lp_wait_cnt = 8'd3;
        pulse_wfe();
        lp_deep = 0;
        chk("R4 stop via wfe", mode, 2);
        chk("R4 lp regulator latched", reg_lp_sel, 1);
        stop_wake = 1; tick(); stop_wake = 0;
        chk("R8 wait still stop", mode, 2);
        chk("R8 osc on during wait", osc_en, 1);
        chk("R8 main regulator during wait", reg_lp_sel, 0);
        n = 0;
        while (mode != 2'd0 && n < 50) begin
            tick(); n++;
        end
        chk("R8 wait length", n, 4);
    endtask

    task automatic t_drain();
        deep_sel = 1; pd_deep = 0; lp_deep = 0; flash_busy = 1;
        pulse_wfi();
        chk("R6 held flash", mode, 0);
        tick(); tick();
        chk("R6 still held", mode, 0);
        flash_busy = 0; apb_busy = 1; tick();
        chk("R6 held apb", mode, 0);
        apb_busy = 0; tick();
        chk("R6 enter after idle", mode, 2);
        stop_wake = 1; tick(); stop_wake = 0;
        chk("R7 back to run", mode, 0);
    endtask

    task automatic t_standby();
        deep_sel = 1; pd_deep = 1; wake_flag = 1;
        pulse_wfi();
        chk("R11 standby refused", mode, 0);
        pd_deep = 0; pulse_wfi();
        chk("R11 stop not blocked", mode, 2);
        stop_wake = 1; tick(); stop_wake = 0; wake_flag = 0;
        pd_deep = 1; wake_pin = 2'b10; flash_busy = 1;
        pulse_wfi();
        flash_busy = 0; tick();
        chk("R5 standby mode", mode, 3);
        chk("R5 regulator off", {reg_on, cpu_clk_en, core_clk_en, osc_en}, 0);
        stop_wake = 1; tick(); stop_wake = 0;
        chk("R10 stop_wake ignored", mode, 3);
        tick();
        chk("R10 held pin ignored", {mode, sys_rst_req}, 6);
        wake_pin = 2'b00; tick();
        wake_pin = 2'b10; tick();
        chk("R10 pin edge reset req", sys_rst_req, 1);
        chk("R10 regulator on in reset", reg_on, 1);
        wake_pin = 2'b00; tick();
        chk("R10 single pulse", sys_rst_req, 0);
        chk("R10 run after reset", mode, 0);
        pulse_wfe();
        chk("R5 standby via wfe", mode, 3);
        rtc_evt = 5'b10000; tick(); rtc_evt = '0;
        chk("R10 rtc exit", sys_rst_req, 1);
        tick();
        pulse_wfi();
        ext_wake_rst = 1; tick(); ext_wake_rst = 0;
        chk("R10 reset source exit", sys_rst_req, 1);
        tick();
        chk("R10 final run", mode, 0);
        deep_sel = 0; pd_deep = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_refuse();
        t_sleep_wfi();
        t_stop_main();
        t_stop_lp();
        t_drain();
        t_standby();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule